// File: doc/BRIEF.md
# Integrate-and-Fire Adder Phase Sequencer

This block is the digital controller of one charge-domain adding unit. The unit sums two operands and a carry by integrating charge onto a main capacitor (A), with a second capacitor (B) beside it. The sequencer runs each addition through a fixed series of phases. It first zeroes both capacitors and autozeroes the comparator. It then writes operand A, operand B and any pending carry through a time-based DAC. When the comparator reports a threshold crossing, it fires a carry and sends all remaining charge to B. After the integration it copies B back onto A. Finally it reads the result out by stepping B up one LSB at a time until the comparator trips.

No logic carry rule exists anywhere in the block. The carry is the comparator's spike alone. The copy-back phase restores the charge that lands past the threshold because of comparator delay. The analog parts (capacitors, comparator, DAC pulse) sit outside and talk to this block through enables and two event inputs. A stand-alone read request re-reads whatever value capacitor A still holds.

Top module: `acc_phase_seq`

## Requirements
- R1: `ready` is high after reset and whenever the sequencer is idle. It falls in the cycle after a request is accepted and rises again in the cycle after the read step that ends the operation.
- R2: An accepted `add_req` first gives one cycle with `az_en`, `dis_a` and `dis_b` all high. In the cycle after that, `dac_start` is high.
- R3: An addition issues exactly two or three DAC writes, in this order: operand A, operand B, then (if a carry is pending) a write of code 1. Each write waits for `dac_done`. Both operands are sampled in the cycle the request is accepted.
- R4: A one-cycle `carry_in` pulse that arrives at any time before the carry phase is held and then used as the third write of code 1. With no carry held, no third write is made.
- R5: The first `cmp_fire` seen during operand or carry integration gives a one-cycle `carry_out` pulse in the next cycle. From that cycle until the next addition, `route_b` stays high. An operation gives at most one `carry_out`.
- R6: `copy_en` is high for exactly one cycle in an addition that overflowed, and never in one that did not.
- R7: `neg_sel_b` is high during the copy and read phases and low during autozero and integration.
- R8: A read first clears B with one `dis_b` cycle. It then alternates an `lsb_b` step with a check cycle. `sum` becomes the number of steps taken before the check that sees `cmp_fire`, so an addition leaves `sum` = (A+B+carry) mod 16.
- R9: If `cmp_fire` has not been seen after 16 steps, `sum` becomes 15 and `sum_err` becomes 1. A read that ends on `cmp_fire` clears `sum_err`.
- R10: Requests and operand changes made while `ready` is low have no effect on the operation in progress.
- R11: A `read_req` in idle runs only the read phase: no autozero, no DAC write, and no copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one period is one LSB of charge |
| rst_n | input | 1 | Asynchronous active-low reset |
| add_req | input | 1 | Start a full addition |
| read_req | input | 1 | Start a read-only operation |
| opa | input | W | First operand |
| opb | input | W | Second operand |
| carry_in | input | 1 | Carry pulse from the lower unit |
| cmp_fire | input | 1 | Comparator output |
| dac_done | input | 1 | Time DAC has finished its pulse |
| az_en | output | 1 | Comparator autozero |
| dis_a | output | 1 | Discharge capacitor A |
| dis_b | output | 1 | Discharge capacitor B |
| route_b | output | 1 | DAC charge goes to B instead of A |
| neg_sel_b | output | 1 | Comparator negative input: 1 = B, 0 = reference |
| copy_en | output | 1 | Transfer B back onto A |
| lsb_b | output | 1 | Add one LSB of charge to B |
| dac_start | output | 1 | Start a DAC write |
| dac_code | output | W | Code for the DAC write |
| carry_out | output | 1 | Carry pulse to the upper unit |
| sum | output | W | Result of the last read |
| sum_err | output | 1 | Last read saturated without a comparator event |
| ready | output | 1 | Idle and accepting requests |

## Verification
Several properties hold on every clock. Autozero is always followed by a DAC start, and a carry pulse never lasts two cycles. A copy is always followed by the read clear, and each LSB step runs with the comparator watching B. A saturated read always shows 15, and ready returns right after the final check. Other behaviour only shows up in the bench's scenarios, which use a charge model of the capacitors and comparator. Those scenarios cover correct sums and carries for every operand pair, the order and codes of the DAC writes, carry pulses arriving before or during an addition, requests and operand changes made while busy, stand-alone reads, and the saturation path with a comparator stuck low.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_AZ,
    ST_A_GO,
    ST_A_W,
    ST_B_GO,
    ST_B_W,
    ST_CRY,
    ST_CRY_W,
    ST_COPY,
    ST_RD_CLR,
    ST_RD_STEP,
    ST_RD_CHK
  } seq_state_e;
endpackage

// File: rtl/acc_carry_latch.sv
module acc_carry_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  input  logic take,
  output logic pend
);
  logic pend_d;

  always_comb begin
    pend_d = pend;
    if (take)     pend_d = 1'b0;
    if (pulse_in) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end

  // R4: a carry pulse is always held on the following cycle
  p_cin_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_in |=> pend);
endmodule

// File: rtl/acc_read_count.sv
module acc_read_count #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         chk,
  input  logic         fire,
  output logic         done,
  output logic [W-1:0] sum,
  output logic         err
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  assign done = chk && (fire || cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)               cnt_d = '0;
    else if (chk && !done) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sum   <= '0;
      err   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (done) begin
        sum <= cnt_q;
        err <= !fire;
      end
    end
  end

  // R9: a saturated read always reports the top code
  p_sat_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> sum == CNT_MAX);
endmodule

// File: rtl/acc_phase_fsm.sv
module acc_phase_fsm
  import acc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         add_req,
  input  logic         read_req,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         dac_done,
  input  logic         cmp_fire,
  input  logic         cin_pend,
  input  logic         rd_done,
  output logic         cin_take,
  output logic         rd_clr,
  output logic         rd_chk,
  output logic         az_en,
  output logic         dis_a,
  output logic         dis_b,
  output logic         route_b,
  output logic         neg_sel_b,
  output logic         copy_en,
  output logic         lsb_b,
  output logic         dac_start,
  output logic [W-1:0] dac_code,
  output logic         carry_out,
  output logic         ready
);
  localparam logic [W-1:0] ONE_LSB = {{(W-1){1'b0}}, 1'b1};

  seq_state_e   state_q, state_d;
  logic         ovf_q;
  logic         cout_q;
  logic [W-1:0] opa_q, opb_q;
  logic         accept_add;
  logic         integrating;
  logic         ovf_hit;

  assign accept_add  = (state_q == ST_IDLE) && add_req;
  assign integrating = state_q inside {ST_A_GO, ST_A_W, ST_B_GO, ST_B_W, ST_CRY, ST_CRY_W};
  assign ovf_hit     = integrating && cmp_fire && !ovf_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (add_req)       state_d = ST_AZ;
        else if (read_req) state_d = ST_RD_CLR;
      end
      ST_AZ:      state_d = ST_A_GO;
      ST_A_GO:    state_d = ST_A_W;
      ST_A_W:     if (dac_done) state_d = ST_B_GO;
      ST_B_GO:    state_d = ST_B_W;
      ST_B_W:     if (dac_done) state_d = ST_CRY;
      ST_CRY:     state_d = cin_pend ? ST_CRY_W : ST_COPY;
      ST_CRY_W:   if (dac_done) state_d = ST_COPY;
      ST_COPY:    state_d = ST_RD_CLR;
      ST_RD_CLR:  state_d = ST_RD_STEP;
      ST_RD_STEP: state_d = ST_RD_CHK;
      ST_RD_CHK:  state_d = rd_done ? ST_IDLE : ST_RD_STEP;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ovf_q   <= 1'b0;
      cout_q  <= 1'b0;
      opa_q   <= '0;
      opb_q   <= '0;
    end else begin
      state_q <= state_d;
      cout_q  <= ovf_hit;
      if (state_q == ST_AZ) ovf_q <= 1'b0;
      else if (ovf_hit)     ovf_q <= 1'b1;
      if (accept_add) begin
        opa_q <= opa;
        opb_q <= opb;
      end
    end
  end

  always_comb begin
    az_en     = (state_q == ST_AZ);
    dis_a     = (state_q == ST_AZ);
    dis_b     = (state_q == ST_AZ) || (state_q == ST_RD_CLR);
    cin_take  = (state_q == ST_CRY) && cin_pend;
    dac_start = (state_q == ST_A_GO) || (state_q == ST_B_GO) || cin_take;
    dac_code  = (state_q == ST_A_GO) ? opa_q :
                (state_q == ST_B_GO) ? opb_q : ONE_LSB;
    neg_sel_b = state_q inside {ST_COPY, ST_RD_CLR, ST_RD_STEP, ST_RD_CHK};
    copy_en   = (state_q == ST_COPY) && ovf_q;
    rd_clr    = (state_q == ST_RD_CLR);
    lsb_b     = (state_q == ST_RD_STEP);
    rd_chk    = (state_q == ST_RD_CHK);
    ready     = (state_q == ST_IDLE);
    route_b   = ovf_q;
    carry_out = cout_q;
  end

  // R2: autozero is followed at once by the first DAC write
  p_az_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    az_en |=> dac_start);
  // R5: the carry pulse lasts a single cycle
  p_cout_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |=> !carry_out);
  // R6: copy-back hands over to the read clear
  p_copy_then_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    copy_en |=> (dis_b && neg_sel_b));
  // R7: every LSB step is compared against capacitor B
  p_step_sense_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lsb_b |=> neg_sel_b);
  // R1: ready returns right after the final check
  p_ready_after_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_chk && rd_done) |=> ready);
  // R10: autozero only starts from idle
  p_az_from_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(az_en) |-> $past(ready));
endmodule

// File: rtl/acc_phase_seq.sv
module acc_phase_seq #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         add_req,
  input  logic         read_req,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         carry_in,
  input  logic         cmp_fire,
  input  logic         dac_done,
  output logic         az_en,
  output logic         dis_a,
  output logic         dis_b,
  output logic         route_b,
  output logic         neg_sel_b,
  output logic         copy_en,
  output logic         lsb_b,
  output logic         dac_start,
  output logic [W-1:0] dac_code,
  output logic         carry_out,
  output logic [W-1:0] sum,
  output logic         sum_err,
  output logic         ready
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       cin_pend, cin_take;
  logic       rd_clr, rd_chk, rd_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  acc_carry_latch u_cin (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pulse_in (carry_in),
    .take     (cin_take),
    .pend     (cin_pend)
  );

  acc_read_count #(.W(W)) u_rd (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (rd_clr),
    .chk   (rd_chk),
    .fire  (cmp_fire),
    .done  (rd_done),
    .sum   (sum),
    .err   (sum_err)
  );

  acc_phase_fsm #(.W(W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .add_req   (add_req),
    .read_req  (read_req),
    .opa       (opa),
    .opb       (opb),
    .dac_done  (dac_done),
    .cmp_fire  (cmp_fire),
    .cin_pend  (cin_pend),
    .rd_done   (rd_done),
    .cin_take  (cin_take),
    .rd_clr    (rd_clr),
    .rd_chk    (rd_chk),
    .az_en     (az_en),
    .dis_a     (dis_a),
    .dis_b     (dis_b),
    .route_b   (route_b),
    .neg_sel_b (neg_sel_b),
    .copy_en   (copy_en),
    .lsb_b     (lsb_b),
    .dac_start (dac_start),
    .dac_code  (dac_code),
    .carry_out (carry_out),
    .ready     (ready)
  );
endmodule

// File: tb/test_acc_phase_seq.sv
`timescale 1ns/1ps
module test_acc_phase_seq;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic add_req, read_req, carry_in, cmp_fire, dac_done;
  logic [W-1:0] opa, opb;
  logic az_en, dis_a, dis_b, route_b, neg_sel_b, copy_en, lsb_b, dac_start;
  logic [W-1:0] dac_code, sum;
  logic carry_out, sum_err, ready;

  int errors = 0;
  int checks = 0;

  // behavioural charge model
  int capA, capB, dac_rem;
  bit dac_act, stuck;
  int n_az, n_copy, n_lsb, n_cout, n_start;
  int codes[$];

  always #2 clk = ~clk;

  acc_phase_seq #(.W(W)) i_acc_phase_seq (
    .clk(clk), .rst_n(rst_n), .add_req(add_req), .read_req(read_req),
    .opa(opa), .opb(opb), .carry_in(carry_in), .cmp_fire(cmp_fire),
    .dac_done(dac_done), .az_en(az_en), .dis_a(dis_a), .dis_b(dis_b),
    .route_b(route_b), .neg_sel_b(neg_sel_b), .copy_en(copy_en),
    .lsb_b(lsb_b), .dac_start(dac_start), .dac_code(dac_code),
    .carry_out(carry_out), .sum(sum), .sum_err(sum_err), .ready(ready)
  );

  always @(negedge clk) begin
    dac_done = 1'b0;
    if (dac_act) begin
      if (dac_rem > 0) begin
        if (route_b) capB++; else capA++;
        dac_rem--;
      end
      if (dac_rem == 0) begin
        dac_done = 1'b1;
        dac_act  = 1'b0;
      end
    end
    if (dac_start) begin
      dac_act = 1'b1;
      dac_rem = int'(dac_code);
      codes.push_back(int'(dac_code));
      n_start++;
    end
    if (dis_a) capA = 0;
    if (dis_b) capB = 0;
    if (copy_en) begin
      capA = capA - 16 + capB;
      capB = 0;
      n_copy++;
    end
    if (lsb_b) begin capB++; n_lsb++; end
    if (az_en) n_az++;
    if (carry_out) n_cout++;
    cmp_fire = stuck ? 1'b0 : (neg_sel_b ? (capB > capA) : (capA >= 16));
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    n_az = 0; n_copy = 0; n_lsb = 0; n_cout = 0; n_start = 0;
    codes.delete();
  endtask

  task automatic wait_ready();
    int guard = 0;
    while (!ready && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check(ready, "R1 ready after op (timeout)", int'(ready), 1);
  endtask

  // cmode: 0 no carry, 1 carry before request, 2 carry during the operation
  task automatic do_add(input int a, input int b, input int cmode, input bit disturb);
    int s;
    s = a + b + (cmode != 0 ? 1 : 0);
    if (cmode == 1) begin
      @(negedge clk); carry_in = 1'b1;
      @(negedge clk); carry_in = 1'b0;
    end
    @(negedge clk);
    clear_counts();
    opa = W'(a); opb = W'(b); add_req = 1'b1;
    @(negedge clk);
    add_req = 1'b0;
    check(!ready, "R1 ready low while busy", int'(ready), 0);
    @(negedge clk);
    if (cmode == 2) carry_in = 1'b1;
    @(negedge clk);
    carry_in = 1'b0;
    if (disturb) begin
      opa = W'(a ^ 5); opb = W'(b ^ 9); add_req = 1'b1; read_req = 1'b1;
      @(negedge clk);
      add_req = 1'b0; read_req = 1'b0;
    end
    wait_ready();
    check(sum == W'(s % 16), "R8 sum", int'(sum), s % 16);
    check(sum_err == 1'b0, "R9 no error", int'(sum_err), 0);
    check(n_cout == (s >= 16 ? 1 : 0), "R5 carry_out count", n_cout, s >= 16 ? 1 : 0);
    check(n_copy == (s >= 16 ? 1 : 0), "R6 copy count", n_copy, s >= 16 ? 1 : 0);
    check(n_az == 1, "R2 autozero once", n_az, 1);
    check(n_start == 2 + (cmode != 0 ? 1 : 0), "R4 DAC write count", n_start, 2 + (cmode != 0 ? 1 : 0));
    if (codes.size() >= 2) begin
      check(codes[0] == a, "R3 first code", codes[0], a);
      check(codes[1] == b, "R3 second code", codes[1], b);
    end
    if (codes.size() == 3)
      check(codes[2] == 1, "R4 carry code", codes[2], 1);
    if (disturb)
      check(n_lsb == (s % 16) + 1, "R10 single read after busy request", n_lsb, (s % 16) + 1);
  endtask

  task automatic do_read(input int exp_sum, input bit exp_err, input int exp_steps);
    @(negedge clk);
    clear_counts();
    read_req = 1'b1;
    @(negedge clk);
    read_req = 1'b0;
    check(!ready, "R1 ready low in read", int'(ready), 0);
    wait_ready();
    check(sum == W'(exp_sum), "R8 read sum", int'(sum), exp_sum);
    check(sum_err == exp_err, "R9 error flag", int'(sum_err), int'(exp_err));
    check(n_lsb == exp_steps, "R8 step count", n_lsb, exp_steps);
    check(n_az == 0 && n_start == 0 && n_copy == 0, "R11 read only", n_az + n_start + n_copy, 0);
  endtask

  initial begin
    #600000;
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    capA = 0; capB = 0; dac_rem = 0; dac_act = 0; stuck = 0;
    cmp_fire = 0; dac_done = 0;
    rst_n = 0; add_req = 0; read_req = 0; carry_in = 0; opa = '0; opb = '0;
    clear_counts();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(ready == 1'b1, "R1 reset ready", int'(ready), 1);
    check(sum == '0 && sum_err == 1'b0, "R8 reset sum", int'(sum), 0);
    check(carry_out == 1'b0 && az_en == 1'b0, "R5 reset carry", int'(carry_out), 0);
    check(neg_sel_b == 1'b0, "R7 idle sense", int'(neg_sel_b), 0);

    do_add(3, 4, 0, 0);
    do_add(10, 10, 1, 0);
    do_add(15, 15, 1, 0);
    do_add(8, 8, 0, 0);
    do_add(15, 0, 2, 0);
    do_add(0, 0, 0, 0);
    do_add(7, 9, 2, 1);
    do_add(2, 3, 0, 1);
    do_read(5, 0, 6);
    // R9 comparator stuck low during read
    stuck = 1;
    do_read(15, 1, 16);
    stuck = 0;
    do_read(5, 0, 6);
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        do_add(a, b, (a + b) % 3, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule